// File: doc/BRIEF.md
# Ones' Complement Index Register Unit

This block keeps the index register of a small 18-bit accumulator machine. The register is a 14-bit ones' complement number: one sign bit and a 13-bit magnitude. The block performs the operations that change or read the register. It can load the register from a memory word, add a memory word to it, write it into the address field of a memory word, set it from the return address of a subroutine jump, and step it toward zero in a count-and-branch loop. It also forms the indexed effective address, which is a 13-bit instruction address plus the register contents.

One operation is applied on each clock edge. The new register value, the memory write-back word with its write strobe, and the branch-taken flag are all registered. They appear one cycle after the operation is presented. The effective address is combinational and always uses the current register value. Memory timing, instruction fetch and accumulator arithmetic belong to the surrounding machine.

In a memory word, the sign is `mem_in[17]` and the address/magnitude field is `mem_in[12:0]`. Inside the register, the sign is `xr_q[13]` and the magnitude is `xr_q[12:0]`.

Top module: `ixr_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds plus zero (all bits 0). In that state `branch` and `mem_wr` are 0 and `mem_out` is 0.
- R2: `op_sel` encoding: 0 idle, 1 load, 2 augment, 3 store-address, 4 call, 5 loop. Codes 0, 6 and 7 leave the register unchanged and give `branch` = 0 and `mem_wr` = 0 on the next cycle.
- R3: Load sets `xr_q[13]` from `mem_in[17]` and `xr_q[12:0]` from `mem_in[12:0]`. It ignores `mem_in[16:13]`.
- R4: Augment sets the register to the 14-bit ones' complement sum of the register and {`mem_in[17]`, `mem_in[12:0]`}. A carry out of bit 13 is added back into bit 0.
- R5: Store-address drives `mem_out` = {`mem_in[17:13]`, `xr_q[12:0]`} with `mem_wr` = 1 for one cycle. The register and its sign do not affect `mem_out[17:13]`. The register is unchanged. `mem_out` holds its value when no store is made.
- R6: Call sets `xr_q[12:0]` to `pc_in` + 1, taken modulo 2^13. It leaves `xr_q[13]` unchanged and raises `branch`.
- R7: Loop on plus zero (all 0) or minus zero (all 1) leaves the register unchanged and gives `branch` = 0.
- R8: Loop on a positive nonzero register reduces its magnitude by one and raises `branch`.
- R9: Loop on a negative nonzero register moves it one step toward zero and raises `branch`.
- R10: A loop step that reaches zero keeps the starting sign. +1 becomes plus zero, and -1 becomes minus zero (all 1).
- R11: `ea` equals the low 13 bits of the 14-bit ones' complement sum of {0, `addr_in`} and the current `xr_q`. It changes in the same cycle as its inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation select (encoding in R2) |
| mem_in | input | 18 | Memory word operand |
| pc_in | input | 13 | Address of the current instruction |
| addr_in | input | 13 | Instruction address field for indexing |
| xr_q | output | 14 | Index register contents |
| mem_out | output | 18 | Word to write back to memory |
| mem_wr | output | 1 | Write-back strobe |
| branch | output | 1 | Branch taken (call and loop) |
| ea | output | 13 | Indexed effective address |

## Verification
The bench goes after the two zeros. It steps +1 and -1 to zero and then loops again. A design that flips the sign of a zero result, or that takes the branch on minus zero, fails these checks. It adds negative operands and minus zero so that the end-around carry decides the result; dropping that carry leaves the sum one too small. It stores into a word whose upper bits are all ones and calls from the last address. These catch a store that clobbers the sign field and a return address that does not wrap.

// File: rtl/ixr_pkg.sv
// Package: shared operation codes for the index register unit.
// Assumes a 3-bit operation select; unlisted codes act as idle.
package ixr_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_AUG   = 3'd2,
        OP_STORE = 3'd3,
        OP_CALL  = 3'd4,
        OP_LOOP  = 3'd5
    } ixr_op_e;
endpackage

// File: rtl/oc_add.sv
// Ones' complement adder: W-bit sum with end-around carry.
// Assumes both operands are W-bit ones' complement numbers.
module oc_add #(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0] raw;

    // Binary sum, then fold the carry back into bit 0.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/ixr_next.sv
// Next-state logic of the index register unit.
// Computes the register, write-back word, strobe and branch flag for one op.
// Assumes memory words carry their sign in the top bit and the field in the low AW bits.
module ixr_next #(
    parameter int AW = 13,
    parameter int WW = 18
) (
    input  logic [2:0]    op,
    input  logic [AW:0]   xr,
    input  logic [WW-1:0] mem_in,
    input  logic [AW-1:0] pc,
    output logic [AW:0]   xr_nxt,
    output logic [WW-1:0] mem_nxt,
    output logic          wr_nxt,
    output logic          br_nxt
);
    import ixr_pkg::*;

    localparam int XW = AW + 1;

    logic [XW-1:0] mem_num;
    logic [XW-1:0] aug_sum;
    logic [XW-1:0] step_in;
    logic [XW-1:0] step_sum;
    logic [XW-1:0] step_res;
    logic          xr_neg;
    logic          xr_zero;

    // Sign and field of the memory word form the 14-bit operand.
    assign mem_num = {mem_in[WW-1], mem_in[AW-1:0]};
    assign xr_neg  = xr[XW-1];
    assign xr_zero = (xr == '0) || (&xr);

    oc_add #(.W(XW)) u_aug (
        .a (xr),
        .b (mem_num),
        .s (aug_sum)
    );

    // Negative values add one; positive values use complement, add one, complement.
    assign step_in = xr_neg ? xr : ~xr;

    oc_add #(.W(XW)) u_step (
        .a (step_in),
        .b ({{(XW-1){1'b0}}, 1'b1}),
        .s (step_sum)
    );

    assign step_res = xr_neg ? step_sum : ~step_sum;

    // Select the outcome of the current operation.
    always_comb begin
        xr_nxt  = xr;
        mem_nxt = {mem_in[WW-1:AW], xr[AW-1:0]};
        wr_nxt  = 1'b0;
        br_nxt  = 1'b0;
        case (op)
            OP_LOAD:  xr_nxt = mem_num;
            OP_AUG:   xr_nxt = aug_sum;
            OP_STORE: wr_nxt = 1'b1;
            OP_CALL: begin
                xr_nxt = {xr[XW-1], pc + {{(AW-1){1'b0}}, 1'b1}};
                br_nxt = 1'b1;
            end
            OP_LOOP: begin
                if (!xr_zero) begin
                    xr_nxt = step_res;
                    br_nxt = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ixr_unit.sv
// Top of the index register unit: holds the register and registered outputs,
// and forms the indexed effective address combinationally.
// Assumes one operation per clock and a synchronous active-low reset.
module ixr_unit #(
    parameter int AW = 13,
    parameter int WW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_sel,
    input  logic [WW-1:0] mem_in,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] addr_in,
    output logic [AW:0]   xr_q,
    output logic [WW-1:0] mem_out,
    output logic          mem_wr,
    output logic          branch,
    output logic [AW-1:0] ea
);
    localparam int XW = AW + 1;

    logic [XW-1:0] xr_nxt;
    logic [WW-1:0] mem_nxt;
    logic          wr_nxt;
    logic          br_nxt;
    logic [XW-1:0] ea_full;

    ixr_next #(.AW(AW), .WW(WW)) u_next (
        .op      (op_sel),
        .xr      (xr_q),
        .mem_in  (mem_in),
        .pc      (pc_in),
        .xr_nxt  (xr_nxt),
        .mem_nxt (mem_nxt),
        .wr_nxt  (wr_nxt),
        .br_nxt  (br_nxt)
    );

    // Register the new state and the per-operation strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xr_q    <= '0;
            mem_out <= '0;
            mem_wr  <= 1'b0;
            branch  <= 1'b0;
        end else begin
            xr_q   <= xr_nxt;
            mem_wr <= wr_nxt;
            branch <= br_nxt;
            if (wr_nxt) mem_out <= mem_nxt;
        end
    end

    oc_add #(.W(XW)) u_ea (
        .a ({1'b0, addr_in}),
        .b (xr_q),
        .s (ea_full)
    );

    assign ea = ea_full[AW-1:0];
endmodule

// File: rtl/ixr_unit_chk.sv
// Checker for the index register unit, bound to every instance of the top.
// Assumes op_sel is driven with known values from time zero.
module ixr_unit_chk #(
    parameter int AW = 13,
    parameter int WW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_sel,
    input logic [WW-1:0] mem_in,
    input logic [AW:0]   xr_q,
    input logic [WW-1:0] mem_out,
    input logic          mem_wr,
    input logic          branch
);
    import ixr_pkg::*;

    logic xr_is_zero;
    assign xr_is_zero = (xr_q == '0) || (&xr_q);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_IDLE || op_sel > OP_LOOP) |=> ($stable(xr_q) && !branch && !mem_wr));

    // R5
    store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_STORE) |=> (mem_wr && mem_out[WW-1:AW] == $past(mem_in[WW-1:AW])
                                  && mem_out[AW-1:0] == $past(xr_q[AW-1:0]) && $stable(xr_q)));

    // R5
    wr_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != OP_STORE) |=> !mem_wr);

    // R6
    call_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CALL) |=> (branch && xr_q[AW] == $past(xr_q[AW])));

    // R7
    loop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LOOP && xr_is_zero) |=> (!branch && $stable(xr_q)));

    // R10
    loop_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LOOP && !xr_is_zero) |=> (branch && xr_q[AW] == $past(xr_q[AW])));
endmodule

bind ixr_unit ixr_unit_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .mem_in  (mem_in),
    .xr_q    (xr_q),
    .mem_out (mem_out),
    .mem_wr  (mem_wr),
    .branch  (branch)
);

// File: tb/ixr_unit_test.sv
module ixr_unit_test;
    localparam int PERIOD = 10;
    localparam int NV = 19;

    typedef struct packed {
        logic [2:0]  op;
        logic [17:0] mem;
        logic [12:0] pc;
        logic [13:0] xr;
        logic [17:0] mo;
        logic        wr;
        logic        br;
        logic [3:0]  req;
    } vec_t;

    // Sequential vectors; register state carries from row to row.
    localparam vec_t TBL [NV] = '{
        '{3'd1, 18'h1E005, 13'h0000, 14'h0005, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3 upper field ignored
        '{3'd2, 18'h00003, 13'h0000, 14'h0008, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4
        '{3'd2, 18'h21FFD, 13'h0000, 14'h0006, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4 end-around carry
        '{3'd3, 18'h3E000, 13'h0000, 14'h0006, 18'h3E006, 1'b1, 1'b0, 4'd5},  // R5
        '{3'd5, 18'h00000, 13'h0000, 14'h0005, 18'h00000, 1'b0, 1'b1, 4'd8},  // R8
        '{3'd0, 18'h3FFFF, 13'h1FFF, 14'h0005, 18'h00000, 1'b0, 1'b0, 4'd2},  // R2 idle
        '{3'd6, 18'h3FFFF, 13'h1FFF, 14'h0005, 18'h00000, 1'b0, 1'b0, 4'd2},  // R2 unused code
        '{3'd1, 18'h00001, 13'h0000, 14'h0001, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd5, 18'h00000, 13'h0000, 14'h0000, 18'h00000, 1'b0, 1'b1, 4'd10}, // R10 +1 -> +0
        '{3'd5, 18'h00000, 13'h0000, 14'h0000, 18'h00000, 1'b0, 1'b0, 4'd7},  // R7 plus zero
        '{3'd1, 18'h21FFE, 13'h0000, 14'h3FFE, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3 negative
        '{3'd5, 18'h00000, 13'h0000, 14'h3FFF, 18'h00000, 1'b0, 1'b1, 4'd10}, // R10 -1 -> -0
        '{3'd5, 18'h00000, 13'h0000, 14'h3FFF, 18'h00000, 1'b0, 1'b0, 4'd7},  // R7 minus zero
        '{3'd1, 18'h21FFC, 13'h0000, 14'h3FFC, 18'h00000, 1'b0, 1'b0, 4'd3},  // R3
        '{3'd5, 18'h00000, 13'h0000, 14'h3FFD, 18'h00000, 1'b0, 1'b1, 4'd9},  // R9
        '{3'd4, 18'h00000, 13'h1FFF, 14'h2000, 18'h00000, 1'b0, 1'b1, 4'd6},  // R6 wrap, sign kept
        '{3'd4, 18'h00000, 13'h0123, 14'h2124, 18'h00000, 1'b0, 1'b1, 4'd6},  // R6
        '{3'd2, 18'h21FFF, 13'h0000, 14'h2124, 18'h00000, 1'b0, 1'b0, 4'd4},  // R4 add minus zero
        '{3'd7, 18'h3FFFF, 13'h0000, 14'h2124, 18'h00000, 1'b0, 1'b0, 4'd2}   // R2 unused code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [17:0] mem_in = '0;
    logic [12:0] pc_in = '0;
    logic [12:0] addr_in = '0;
    logic [13:0] xr_q;
    logic [17:0] mem_out;
    logic        mem_wr;
    logic        branch;
    logic [12:0] ea;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ixr_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .mem_in  (mem_in),
        .pc_in   (pc_in),
        .addr_in (addr_in),
        .xr_q    (xr_q),
        .mem_out (mem_out),
        .mem_wr  (mem_wr),
        .branch  (branch),
        .ea      (ea)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [17:0] m, input logic [12:0] pc);
        op_sel = op;
        mem_in = m;
        pc_in  = pc;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        check("R1", {xr_q, mem_out, mem_wr, branch}, {14'h0, 18'h0, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {xr_q, mem_wr, branch}, {14'h0, 1'b0, 1'b0});
        // R11 with plus zero
        addr_in = 13'h1FFF; #1;
        check("R11", ea, 13'h1FFF);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].op, TBL[i].mem, TBL[i].pc);
            checks++;
            if (xr_q !== TBL[i].xr || mem_wr !== TBL[i].wr || branch !== TBL[i].br
                || (TBL[i].wr && mem_out !== TBL[i].mo)) begin
                fails++;
                $display("FAIL R%0d row %0d actual xr=%h wr=%b br=%b mo=%h expected xr=%h wr=%b br=%b mo=%h",
                         TBL[i].req, i, xr_q, mem_wr, branch, mem_out,
                         TBL[i].xr, TBL[i].wr, TBL[i].br, TBL[i].mo);
            end
        end

        // R5 mem_out holds after the store
        check("R5", mem_out, 18'h3E006);

        // R11 positive and negative index
        step(3'd1, 18'h00003, 13'h0);
        addr_in = 13'h000A; #1;
        check("R11", ea, 13'h000D);
        step(3'd1, 18'h21FFC, 13'h0);
        addr_in = 13'h000A; #1;
        check("R11", ea, 13'h0007);

        // R1 reset in mid-run clears the register
        step(3'd5, 18'h0, 13'h0);
        check("R9", xr_q, 14'h3FFD);
        rst_n = 1'b0;
        op_sel = 3'd0;
        @(negedge clk);
        check("R1", {xr_q, branch, mem_wr}, {14'h0, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule